// File: doc/BRIEF.md
# Bit Manipulation and Carry-Bit Unit

This unit carries out single-bit work for a small 8-bit processor core. It can force one bit of a memory byte high or low. It can decide a bit-test branch, and it can fold any memory bit into the carry flag with AND, OR or XOR. It can also flip a memory bit and move a bit between memory and carry in either direction. Two more operations, test-and-set and test-and-clear, apply the accumulator as a mask to a whole byte and update the N and Z flags.

The core sets `valid_i` for one cycle and presents a control byte, the fetched memory byte, the accumulator and the current carry. One clock later the unit shows its result on registered outputs. These outputs are the byte to store with its write strobe, the new carry, N and Z with their update strobe, and the branch decision. The core does its own bus timing and branch-target arithmetic. The unit accepts a new operation every cycle.

Top module: `bitu`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after it goes high, `valid_o`, `we_o`, `wdata_o`, `carry_o`, `nz_we_o`, `n_o`, `z_o` and `taken_o` are all 0.
- R2: A result appears on the outputs one clock after `valid_i` is sampled high. `valid_o` is high for exactly that cycle. Whenever `valid_o` is low, `we_o`, `nz_we_o` and `taken_o` are low.
- R3: Control byte bits [4:0] select the operation. Bits [7:5] give the bit index for kinds 0 to 3. `bsel_i` gives the bit index for kinds 4 to 9.
- R4: Kind 0 (set) writes `mem_i` with the indexed bit forced to 1. Kind 1 (clear) writes it with that bit forced to 0. All other bits pass through unchanged, and the carry is unchanged.
- R5: Kind 2 raises `taken_o` when the indexed bit of `mem_i` is 1. Kind 3 raises it when that bit is 0. Neither kind writes memory.
- R6: Kinds 4, 5 and 6 set the carry to carry AND bit, carry OR bit and carry XOR bit. The bit is selected by `bsel_i`. None of them writes memory.
- R7: Kind 7 writes `mem_i` with the selected bit inverted and leaves the carry unchanged.
- R8: Kind 8 copies the selected bit into the carry without writing. Kind 9 writes `mem_i` with the selected bit replaced by `carry_i`.
- R9: Kind 10 writes `mem_i | acc_i`. Kind 11 writes `mem_i & ~acc_i`. Both raise `nz_we_o`, with `n_o` taken from bit 7 of `acc_i - mem_i` and `z_o` high when that difference is zero.
- R10: Kinds 12 to 31 produce `valid_o` with no write, no branch and no flag update, and the carry is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| opc_i | input | 8 | Control byte: [7:5] bit index, [4:0] kind |
| bsel_i | input | 3 | Bit index for carry, invert and move kinds |
| mem_i | input | 8 | Memory byte operand |
| acc_i | input | 8 | Accumulator (mask for test kinds) |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result present |
| we_o | output | 1 | Memory write strobe |
| wdata_o | output | 8 | Byte to write |
| carry_o | output | 1 | New carry flag |
| nz_we_o | output | 1 | N/Z update strobe |
| n_o | output | 1 | New N flag |
| z_o | output | 1 | New Z flag |
| taken_o | output | 1 | Branch decision |

## Verification
Test-and-set and test-and-clear produce a memory write and an N/Z update in the same result cycle. The bench uses accumulator and memory pairs that make the difference zero, negative and positive. It judges the stored byte and both flags together. The move-to-memory kind also stores a byte built from the incoming carry in the same cycle that the carry passes through. Back-to-back operations with `valid_i` held high check that each result lands on its own cycle and no earlier one leaks into it.

// File: rtl/bitu_pkg.sv
package bitu_pkg;
  typedef enum logic [4:0] {
    K_SET  = 5'd0,
    K_CLR  = 5'd1,
    K_BRS  = 5'd2,
    K_BRC  = 5'd3,
    K_CAND = 5'd4,
    K_COR  = 5'd5,
    K_CXOR = 5'd6,
    K_INV  = 5'd7,
    K_LDC  = 5'd8,
    K_STC  = 5'd9,
    K_TSET = 5'd10,
    K_TCLR = 5'd11
  } kind_e;

  typedef struct packed {
    logic       we;
    logic [7:0] wdata;
    logic       carry;
    logic       nz_we;
    logic       n;
    logic       z;
    logic       taken;
  } res_t;
endpackage

// File: rtl/bitu_mask.sv
module bitu_mask #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic [IW-1:0] idx_i,
  output logic [DW-1:0] mask_o
);
  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign mask_o[g] = (idx_i == IW'(g));
  end
endmodule

// File: rtl/bitu_alu.sv
module bitu_alu
  import bitu_pkg::*;
(
  input  logic [4:0] kind_i,
  input  logic [7:0] mask_op_i,
  input  logic [7:0] mask_sel_i,
  input  logic [7:0] mem_i,
  input  logic [7:0] acc_i,
  input  logic       carry_i,
  output res_t       res_o
);
  logic       bit_op, bit_sel;
  logic [7:0] diff;

  assign bit_op  = |(mem_i & mask_op_i);
  assign bit_sel = |(mem_i & mask_sel_i);
  assign diff    = acc_i - mem_i;

  always_comb begin
    res_o       = '0;
    res_o.carry = carry_i;
    res_o.wdata = mem_i;
    case (kind_i)
      K_SET:  begin res_o.we = 1'b1; res_o.wdata = mem_i | mask_op_i;  end
      K_CLR:  begin res_o.we = 1'b1; res_o.wdata = mem_i & ~mask_op_i; end
      K_BRS:  res_o.taken = bit_op;
      K_BRC:  res_o.taken = ~bit_op;
      K_CAND: res_o.carry = carry_i & bit_sel;
      K_COR:  res_o.carry = carry_i | bit_sel;
      K_CXOR: res_o.carry = carry_i ^ bit_sel;
      K_INV:  begin res_o.we = 1'b1; res_o.wdata = mem_i ^ mask_sel_i; end
      K_LDC:  res_o.carry = bit_sel;
      K_STC: begin
        res_o.we    = 1'b1;
        res_o.wdata = carry_i ? (mem_i | mask_sel_i) : (mem_i & ~mask_sel_i);
      end
      K_TSET, K_TCLR: begin
        res_o.we    = 1'b1;
        res_o.wdata = (kind_i == K_TSET) ? (mem_i | acc_i) : (mem_i & ~acc_i);
        res_o.nz_we = 1'b1;
        res_o.n     = diff[7];
        res_o.z     = (diff == 8'h00);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitu.sv
module bitu
  import bitu_pkg::*;
#(
  parameter int DW = 8,
  localparam int IW = $clog2(DW),
  localparam int KW = 8 - IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [7:0]    opc_i,
  input  logic [IW-1:0] bsel_i,
  input  logic [7:0]    mem_i,
  input  logic [7:0]    acc_i,
  input  logic          carry_i,
  output logic          valid_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          carry_o,
  output logic          nz_we_o,
  output logic          n_o,
  output logic          z_o,
  output logic          taken_o
);
  logic [DW-1:0] mask_op, mask_sel;
  logic [4:0]    kind;
  res_t          res, res_q;
  logic          vld_q;

  assign kind = 5'(opc_i[KW-1:0]);

  bitu_mask #(.DW(DW)) u_mask_op  (.idx_i(opc_i[7 -: IW]), .mask_o(mask_op));
  bitu_mask #(.DW(DW)) u_mask_sel (.idx_i(bsel_i),         .mask_o(mask_sel));

  bitu_alu u_alu (
    .kind_i    (kind),
    .mask_op_i (8'(mask_op)),
    .mask_sel_i(8'(mask_sel)),
    .mem_i     (mem_i),
    .acc_i     (acc_i),
    .carry_i   (carry_i),
    .res_o     (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid_i;
      res_q <= valid_i ? res : '0;
    end
  end

  assign valid_o = vld_q;
  assign we_o    = res_q.we;
  assign wdata_o = res_q.wdata;
  assign carry_o = res_q.carry;
  assign nz_we_o = res_q.nz_we;
  assign n_o     = res_q.n;
  assign z_o     = res_q.z;
  assign taken_o = res_q.taken;

  // R2: strobes only with a result
  a_r2_strobe_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(we_o || nz_we_o || taken_o));
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r5_branch_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_o, taken_o}));
  a_r4_set_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind == K_SET) |=> (we_o && ((wdata_o | $past(mem_i)) == wdata_o)));
  a_r6_carry_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind == K_CAND || kind == K_COR || kind == K_CXOR || kind == K_LDC))
      |=> !we_o);
  a_r8_load_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind == K_LDC) |=> (carry_o == $past(mem_i[bsel_i])));
  a_r9_test_nz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind == K_TSET || kind == K_TCLR)) |=> (nz_we_o && we_o));
  a_r10_unused_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind > K_TCLR) |=> !(we_o || nz_we_o || taken_o) && carry_o == $past(carry_i));
endmodule

// File: tb/bitu_test.sv
module bitu_test;
  localparam time TCLK = 10ns;

  logic       clk = 0, rst_n = 0, valid = 0, carry = 0;
  logic [7:0] opc = 0, mem = 0, acc = 0;
  logic [2:0] bsel = 0;
  logic       valid_o, we_o, carry_o, nz_we_o, n_o, z_o, taken_o;
  logic [7:0] wdata_o;
  int         errs = 0, checks = 0;

  always #(TCLK/2) clk = ~clk;

  bitu uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opc_i(opc), .bsel_i(bsel),
    .mem_i(mem), .acc_i(acc), .carry_i(carry), .valid_o(valid_o), .we_o(we_o),
    .wdata_o(wdata_o), .carry_o(carry_o), .nz_we_o(nz_we_o), .n_o(n_o),
    .z_o(z_o), .taken_o(taken_o)
  );

  // packed: valid we wdata carry nz_we n z taken
  function automatic logic [14:0] pack_out();
    return {valid_o, we_o, wdata_o, carry_o, nz_we_o, n_o, z_o, taken_o};
  endfunction

  function automatic logic [14:0] model(input logic [7:0] o, input logic [2:0] s,
                                        input logic [7:0] m, input logic [7:0] a,
                                        input logic c);
    logic we = 0, nzw = 0, n = 0, z = 0, tk = 0, cn = c;
    logic [7:0] wd = m, d;
    logic bo = m[o[7:5]], bs = m[s];
    d = a - m;
    case (o[4:0])
      0: begin we = 1; wd[o[7:5]] = 1'b1; end
      1: begin we = 1; wd[o[7:5]] = 1'b0; end
      2: tk = bo;
      3: tk = !bo;
      4: cn = c & bs;
      5: cn = c | bs;
      6: cn = c ^ bs;
      7: begin we = 1; wd[s] = !bs; end
      8: cn = bs;
      9: begin we = 1; wd[s] = c; end
      10, 11: begin
        we = 1; wd = (o[4:0] == 10) ? (m | a) : (m & ~a);
        nzw = 1; n = d[7]; z = (d == 0);
      end
      default: ;
    endcase
    return {1'b1, we, wd, cn, nzw, n, z, tk};
  endfunction

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [7:0] o, input logic [2:0] s,
                     input logic [7:0] m, input logic [7:0] a, input logic c);
    @(negedge clk);
    valid = 1; opc = o; bsel = s; mem = m; acc = a; carry = c;
    @(negedge clk);
    valid = 0;
    check(req, pack_out(), model(o, s, m, a, c));
  endtask

  task automatic t_reset();
    check("R1", pack_out(), '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", pack_out(), '0);
  endtask

  task automatic t_setclr();
    run("R4", {3'd0, 5'd0}, 3'd5, 8'h00, 8'h00, 1'b1);
    run("R4", {3'd7, 5'd0}, 3'd0, 8'h12, 8'h00, 1'b0);
    run("R4", {3'd3, 5'd1}, 3'd0, 8'hFF, 8'h00, 1'b1);
    run("R3", {3'd6, 5'd1}, 3'd1, 8'h40, 8'h00, 1'b0);
  endtask

  task automatic t_branch();
    run("R5", {3'd4, 5'd2}, 3'd0, 8'h10, 8'h00, 1'b0);
    run("R5", {3'd4, 5'd2}, 3'd4, 8'hEF, 8'h00, 1'b0);
    run("R5", {3'd0, 5'd3}, 3'd0, 8'hFE, 8'h00, 1'b1);
    run("R5", {3'd7, 5'd3}, 3'd0, 8'h80, 8'h00, 1'b1);
  endtask

  task automatic t_carry();
    run("R6", {3'd0, 5'd4}, 3'd2, 8'h04, 8'h00, 1'b1);
    run("R6", {3'd2, 5'd4}, 3'd3, 8'h04, 8'h00, 1'b1);
    run("R6", {3'd0, 5'd5}, 3'd7, 8'h80, 8'h00, 1'b0);
    run("R6", {3'd0, 5'd5}, 3'd6, 8'h80, 8'h00, 1'b0);
    run("R6", {3'd0, 5'd6}, 3'd1, 8'h02, 8'h00, 1'b1);
    run("R6", {3'd0, 5'd6}, 3'd1, 8'h02, 8'h00, 1'b0);
  endtask

  task automatic t_inv_mov();
    run("R7", {3'd0, 5'd7}, 3'd3, 8'hA5, 8'h00, 1'b1);
    run("R7", {3'd0, 5'd7}, 3'd0, 8'hA5, 8'h00, 1'b0);
    run("R8", {3'd0, 5'd8}, 3'd5, 8'h20, 8'h00, 1'b0);
    run("R8", {3'd0, 5'd8}, 3'd5, 8'hDF, 8'h00, 1'b1);
    run("R8", {3'd0, 5'd9}, 3'd2, 8'h00, 8'h00, 1'b1);
    run("R8", {3'd0, 5'd9}, 3'd7, 8'hFF, 8'h00, 1'b0);
  endtask

  task automatic t_test();
    run("R9", {3'd0, 5'd10}, 3'd0, 8'h3C, 8'h3C, 1'b0);  // diff zero
    run("R9", {3'd0, 5'd10}, 3'd0, 8'h50, 8'h0F, 1'b1);  // diff negative
    run("R9", {3'd0, 5'd11}, 3'd0, 8'hF0, 8'hFF, 1'b0);  // diff positive
    run("R9", {3'd0, 5'd11}, 3'd0, 8'h81, 8'h01, 1'b1);
  endtask

  task automatic t_unused();
    run("R10", {3'd5, 5'd12}, 3'd1, 8'hFF, 8'hAA, 1'b1);
    run("R10", {3'd2, 5'd31}, 3'd7, 8'h00, 8'h55, 1'b0);
  endtask

  // R2: back-to-back results, then idle
  task automatic t_stream();
    logic [14:0] e1, e2;
    e1 = model({3'd1, 5'd0}, 3'd0, 8'h00, 8'h00, 1'b0);
    e2 = model({3'd0, 5'd10}, 3'd0, 8'h01, 8'h01, 1'b1);
    @(negedge clk);
    valid = 1; opc = {3'd1, 5'd0}; bsel = 0; mem = 8'h00; acc = 8'h00; carry = 0;
    @(negedge clk);
    check("R2", pack_out(), e1);
    opc = {3'd0, 5'd10}; mem = 8'h01; acc = 8'h01; carry = 1;
    @(negedge clk);
    valid = 0;
    check("R2", pack_out(), e2);
    @(negedge clk);
    check("R2", {valid_o, we_o, nz_we_o, taken_o}, 4'b0000);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_setclr(); t_branch(); t_carry();
        t_inv_mov(); t_test(); t_unused(); t_stream();
      end
      begin
        #(TCLK * 5000);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule